// File: doc/BRIEF.md
# Carrier Sense and Collision Controller

This block sits between the receive and collision detection front end of a Manchester line interface and the link-layer controller. It produces two outputs for the controller: carrier sense and collision. It recognises a collision from a roughly periodic square-wave indication by watching for edges. It merges receive activity and collision activity into carrier sense, which changes only on receive-clock enable cycles. After the node's own transmission ends it holds carrier sense off for a fixed window.

A loopback select disconnects the external receive and collision indications. In loopback, carrier sense follows the node's own transmit enable. A synthetic collision pulse is produced a fixed delay after carrier sense falls, as a signal-quality self test. A watchdog abort input forces carrier sense off at once. A polarity input makes both outputs active low. All timing is counted in cycles of the block clock, which is nominally 20 MHz.

Top module: `cscd_ctrl`

## Requirements
- R1: After reset, with `alt_polarity` low and no activity, `crs_out` and `coll_out` are both 0.
- R2: Edges on `coll_sig` spaced no more than `COLL_TIMEOUT` cycles apart mark collision activity. While activity is marked, `coll_out` is active, and this does not depend on `rxc_tick`.
- R3: Collision activity ends `COLL_TIMEOUT` cycles after the last edge seen on `coll_sig`. The collision output is still active 3 cycles after the last input toggle and is inactive within 15 cycles.
- R4: Carrier sense follows (`rx_active` OR collision activity). It changes only on clock edges where `rxc_tick` is 1: it is set on the first such edge after the merged activity rises, and it holds its value while `rxc_tick` is 0.
- R5: Carrier sense stays asserted until both receive activity and collision activity have ended, whichever ends later.
- R6: Carrier sense may fall on an edge F after `tx_en` has been high at any time since the last such window. It then stays 0 on edges F+1 through F+`INHIBIT_CYC` (default 90) and may rise again on edge F+`INHIBIT_CYC`+1. This holds even with collision activity present, and `coll_out` still shows that activity during the window.
- R7: A fall of carrier sense with no transmission since the last window starts no hold-off: carrier sense can rise again on the next `rxc_tick` edge.
- R8: While `wdog_abort` is 1, carrier sense is 0 from the next clock edge, whatever the value of `rxc_tick`.
- R9: While `loopback` is 1, `rx_active` and `coll_sig` have no effect on either output. Carrier sense follows `tx_en` on `rxc_tick` edges.
- R10: In loopback, when carrier sense falls on edge F, `coll_out` is active on edges F+`SQE_DELAY`+1 through F+`SQE_DELAY`+`SQE_LEN` (defaults F+12 through F+24) and inactive on the edges just before and just after that range.
- R11: When `alt_polarity` is 1, both outputs are inverted, so 1 means inactive and 0 means active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (20 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| rx_active | input | 1 | Receive data present on the line |
| coll_sig | input | 1 | Digitised collision square-wave indication |
| rxc_tick | input | 1 | Receive-clock enable; carrier sense updates on these edges |
| tx_en | input | 1 | Node transmit enable |
| wdog_abort | input | 1 | Transmit watchdog expired |
| loopback | input | 1 | Loopback select |
| alt_polarity | input | 1 | 1 selects active-low outputs |
| crs_out | output | 1 | Carrier sense toward the controller |
| coll_out | output | 1 | Collision toward the controller |

## Verification
Two functions can act in the same cycle: the hold-off window after the node's own transmission, and collision detection. The bench provokes this by starting the collision square wave on the same cycle that transmission and reception stop. The collision detector then asserts its activity while the window is already running. The outputs are judged at several points: carrier sense must stay low for exactly the window length and rise on the first edge after it, while the collision output must be active in the middle of the window. A second overlap occurs in loopback, where the self-test pulse falls inside the same hold-off window while live collision toggling is present and must be ignored.

// File: rtl/cscd_pkg.sv
package cscd_pkg;

    localparam int DEF_INHIBIT_CYC  = 90;
    localparam int DEF_SQE_DELAY    = 11;
    localparam int DEF_SQE_LEN      = 13;
    localparam int DEF_COLL_TIMEOUT = 4;

    typedef enum logic [1:0] {
        SQE_IDLE,
        SQE_WAIT,
        SQE_FIRE
    } sqe_state_e;

    typedef struct packed {
        logic crs;
        logic coll;
    } cscd_lines_t;

    function automatic cscd_lines_t drive_lines(input logic crs, input logic coll,
                                                input logic alt);
        cscd_lines_t v;
        v.crs  = crs ^ alt;
        v.coll = coll ^ alt;
        return v;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cscd_coll_det.sv
module cscd_coll_det #(
    parameter int TIMEOUT = cscd_pkg::DEF_COLL_TIMEOUT
) (
    input  logic clk,
    input  logic rst,
    input  logic coll_sig,
    output logic active
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [2:0]    shr;
    logic          edge_seen;
    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) shr <= '0;
        else     shr <= {shr[1:0], coll_sig};
    end

    assign edge_seen = shr[2] ^ shr[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            idle_cnt <= '0;
        end else if (edge_seen) begin
            active   <= 1'b1;
            idle_cnt <= '0;
        end else if (active) begin
            if (idle_cnt == CW'(TIMEOUT - 1)) active <= 1'b0;
            else                              idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cscd_post_tx.sv
module cscd_post_tx
    import cscd_pkg::*;
#(
    parameter int INHIBIT_CYC = DEF_INHIBIT_CYC,
    parameter int SQE_DELAY   = DEF_SQE_DELAY,
    parameter int SQE_LEN     = DEF_SQE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic loopback,
    output logic inhibit,
    output logic sqe_pulse
);
    localparam int IW = $clog2(INHIBIT_CYC + 1);
    localparam int SW = $clog2(max_int(SQE_DELAY, SQE_LEN) + 1);

    logic [IW-1:0] inh_cnt;
    logic [SW-1:0] sqe_cnt;
    sqe_state_e    sqe_st;

    always_ff @(posedge clk) begin
        if (rst)                 inh_cnt <= '0;
        else if (start)          inh_cnt <= IW'(INHIBIT_CYC - 1);
        else if (inh_cnt != '0)  inh_cnt <= inh_cnt - 1'b1;
    end

    assign inhibit = start | (inh_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sqe_st  <= SQE_IDLE;
            sqe_cnt <= '0;
        end else if (start && loopback) begin
            sqe_st  <= SQE_WAIT;
            sqe_cnt <= '0;
        end else begin
            case (sqe_st)
                SQE_WAIT: begin
                    if (sqe_cnt == SW'(SQE_DELAY - 1)) begin
                        sqe_st  <= SQE_FIRE;
                        sqe_cnt <= '0;
                    end else begin
                        sqe_cnt <= sqe_cnt + 1'b1;
                    end
                end
                SQE_FIRE: begin
                    if (sqe_cnt == SW'(SQE_LEN - 1)) begin
                        sqe_st  <= SQE_IDLE;
                        sqe_cnt <= '0;
                    end else begin
                        sqe_cnt <= sqe_cnt + 1'b1;
                    end
                end
                default: sqe_cnt <= '0;
            endcase
        end
    end

    assign sqe_pulse = (sqe_st == SQE_FIRE);
endmodule

// File: rtl/cscd_ctrl.sv
module cscd_ctrl
    import cscd_pkg::*;
#(
    parameter int INHIBIT_CYC  = DEF_INHIBIT_CYC,
    parameter int SQE_DELAY    = DEF_SQE_DELAY,
    parameter int SQE_LEN      = DEF_SQE_LEN,
    parameter int COLL_TIMEOUT = DEF_COLL_TIMEOUT
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_active,
    input  logic coll_sig,
    input  logic rxc_tick,
    input  logic tx_en,
    input  logic wdog_abort,
    input  logic loopback,
    input  logic alt_polarity,
    output logic crs_out,
    output logic coll_out
);
    logic        coll_active;
    logic        inhibit;
    logic        sqe_pulse;
    logic        crs_q;
    logic        crs_d1;
    logic        tx_seen;
    logic        win_start;
    logic        merged;
    logic        coll_int;
    cscd_lines_t lines;

    cscd_coll_det #(.TIMEOUT(COLL_TIMEOUT)) u_coll (
        .clk      (clk),
        .rst      (rst),
        .coll_sig (coll_sig),
        .active   (coll_active)
    );

    // Carrier sense just fell after the node had transmitted.
    assign win_start = crs_d1 & ~crs_q & tx_seen;

    cscd_post_tx #(
        .INHIBIT_CYC (INHIBIT_CYC),
        .SQE_DELAY   (SQE_DELAY),
        .SQE_LEN     (SQE_LEN)
    ) u_post (
        .clk       (clk),
        .rst       (rst),
        .start     (win_start),
        .loopback  (loopback),
        .inhibit   (inhibit),
        .sqe_pulse (sqe_pulse)
    );

    assign merged = loopback ? tx_en : (rx_active | coll_active);

    always_ff @(posedge clk) begin
        if (rst)             crs_q <= 1'b0;
        else if (wdog_abort) crs_q <= 1'b0;
        else if (rxc_tick)   crs_q <= merged & ~inhibit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crs_d1  <= 1'b0;
            tx_seen <= 1'b0;
        end else begin
            crs_d1  <= crs_q;
            tx_seen <= (tx_seen & ~win_start) | tx_en;
        end
    end

    assign coll_int = loopback ? sqe_pulse : coll_active;
    assign lines    = drive_lines(crs_q, coll_int, alt_polarity);
    assign crs_out  = lines.crs;
    assign coll_out = lines.coll;
endmodule

// File: rtl/cscd_ctrl_chk.sv
module cscd_ctrl_chk #(
    parameter int INHIBIT_CYC = cscd_pkg::DEF_INHIBIT_CYC
) (
    input logic clk,
    input logic rst,
    input logic crs_q,
    input logic tx_seen,
    input logic coll_active,
    input logic sqe_pulse,
    input logic loopback,
    input logic alt_polarity,
    input logic coll_out,
    input logic rxc_tick,
    input logic wdog_abort
);
    localparam int KW = $clog2(INHIBIT_CYC + 1);

    logic          prev_crs;
    logic [KW-1:0] hold_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_crs  <= 1'b0;
            hold_left <= '0;
        end else begin
            prev_crs <= crs_q;
            if (prev_crs && !crs_q && tx_seen) hold_left <= KW'(INHIBIT_CYC);
            else if (hold_left != '0)          hold_left <= hold_left - 1'b1;
        end
    end

    p_tick_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!rxc_tick && !wdog_abort) |=> $stable(crs_q));

    p_abort_drop_r8: assert property (@(posedge clk) disable iff (rst)
        wdog_abort |=> !crs_q);

    p_inhibit_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_left != '0) |-> !crs_q);

    p_coll_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (coll_active && !loopback) |-> (coll_out != alt_polarity));

    p_loop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (loopback && !sqe_pulse) |-> (coll_out == alt_polarity));
endmodule

bind cscd_ctrl cscd_ctrl_chk #(.INHIBIT_CYC(INHIBIT_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .crs_q        (crs_q),
    .tx_seen      (tx_seen),
    .coll_active  (coll_active),
    .sqe_pulse    (sqe_pulse),
    .loopback     (loopback),
    .alt_polarity (alt_polarity),
    .coll_out     (coll_out),
    .rxc_tick     (rxc_tick),
    .wdog_abort   (wdog_abort)
);

// File: tb/cscd_ctrl_test.sv
module cscd_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_active = 1'b0, coll_sig = 1'b0, rxc_tick = 1'b1, tx_en = 1'b0;
    logic wdog_abort = 1'b0, loopback = 1'b0, alt_polarity = 1'b0;
    logic crs_out, coll_out;

    int  cyc = 0;
    int  checks = 0;
    int  failures = 0;
    bit  coll_run = 1'b0;
    bit  phase = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        int    at;
        string req;
        bit    is_coll;
        logic  val;
    } exp_t;
    exp_t sb[$];

    cscd_ctrl uut (
        .clk(clk), .rst(rst), .rx_active(rx_active), .coll_sig(coll_sig),
        .rxc_tick(rxc_tick), .tx_en(tx_en), .wdog_abort(wdog_abort),
        .loopback(loopback), .alt_polarity(alt_polarity),
        .crs_out(crs_out), .coll_out(coll_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Collision square wave: one toggle every two cycles while enabled.
    always @(posedge clk) begin
        #3;
        if (coll_run) begin
            phase = !phase;
            if (phase) coll_sig = !coll_sig;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic exp_crs(input int k, input logic v, input string req);
        exp_t e;
        e.at = cyc + k; e.req = req; e.is_coll = 1'b0; e.val = v;
        sb.push_back(e);
    endtask

    task automatic exp_coll(input int k, input logic v, input string req);
        exp_t e;
        e.at = cyc + k; e.req = req; e.is_coll = 1'b1; e.val = v;
        sb.push_back(e);
    endtask

    // Monitor: compares queued expectations as their cycle comes up.
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].at == cyc) begin
                    logic act;
                    act = sb[i].is_coll ? coll_out : crs_out;
                    checks++;
                    if (act !== sb[i].val) begin
                        failures++;
                        $display("FAIL %s %s at cycle %0d: actual=%b expected=%b",
                                 sb[i].req, sb[i].is_coll ? "coll_out" : "crs_out",
                                 cyc, act, sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        step(4);
        rst = 1'b0;
        exp_crs(1, 1'b0, "R1"); exp_coll(1, 1'b0, "R1");
        step(3);

        // Receive only, then immediate re-receive with no hold-off.
        rx_active = 1'b1; exp_crs(1, 1'b1, "R4");
        step(5);
        rx_active = 1'b0; exp_crs(1, 1'b0, "R7");
        step(1);
        rx_active = 1'b1; exp_crs(1, 1'b1, "R7");
        step(3);
        rx_active = 1'b0;
        step(3);

        // Updates gated by the receive-clock enable.
        rxc_tick = 1'b0; rx_active = 1'b1;
        exp_crs(1, 1'b0, "R4"); exp_crs(2, 1'b0, "R4");
        step(2);
        rxc_tick = 1'b1; exp_crs(1, 1'b1, "R4");
        step(3);
        rx_active = 1'b0;
        step(3);

        // Collision alone, then receive outlasting collision.
        coll_run = 1'b1;
        exp_coll(8, 1'b1, "R2"); exp_crs(8, 1'b1, "R4");
        step(10);
        rx_active = 1'b1;
        step(10);
        coll_run = 1'b0;
        exp_coll(3, 1'b1, "R3"); exp_coll(15, 1'b0, "R3"); exp_crs(15, 1'b1, "R5");
        step(15);
        rx_active = 1'b0; exp_crs(1, 1'b0, "R5");
        step(5);

        // Collision outlasting receive.
        rx_active = 1'b1; coll_run = 1'b1;
        step(10);
        rx_active = 1'b0; exp_crs(5, 1'b1, "R5");
        step(5);
        coll_run = 1'b0; exp_crs(20, 1'b0, "R5"); exp_coll(20, 1'b0, "R3");
        step(22);

        // Own transmission, then a collision inside the hold-off window.
        tx_en = 1'b1; rx_active = 1'b1; exp_crs(1, 1'b1, "R4");
        step(20);
        tx_en = 1'b0; rx_active = 1'b0; coll_run = 1'b1;
        exp_crs(1, 1'b0, "R6");
        exp_crs(2, 1'b0, "R6");
        exp_crs(50, 1'b0, "R6"); exp_coll(50, 1'b1, "R6");
        exp_crs(91, 1'b0, "R6");
        exp_crs(92, 1'b1, "R6");
        step(100);
        coll_run = 1'b0;
        step(25);
        exp_crs(1, 1'b0, "R3"); exp_coll(1, 1'b0, "R3");
        step(3);

        // Watchdog abort with the tick held off.
        rx_active = 1'b1;
        step(3);
        rxc_tick = 1'b0; wdog_abort = 1'b1; exp_crs(1, 1'b0, "R8");
        step(1);
        wdog_abort = 1'b0; rxc_tick = 1'b1; exp_crs(1, 1'b1, "R8");
        step(3);
        rx_active = 1'b0;
        step(3);

        // Loopback: external inputs ignored, self-test pulse after transmit.
        loopback = 1'b1; rx_active = 1'b1; coll_run = 1'b1;
        exp_crs(10, 1'b0, "R9"); exp_coll(10, 1'b0, "R9");
        step(10);
        tx_en = 1'b1; exp_crs(1, 1'b1, "R9");
        step(20);
        tx_en = 1'b0; exp_crs(1, 1'b0, "R9");
        exp_coll(12, 1'b0, "R10"); exp_coll(13, 1'b1, "R10");
        exp_coll(25, 1'b1, "R10"); exp_coll(26, 1'b0, "R10");
        exp_crs(40, 1'b0, "R9");
        step(30);
        coll_run = 1'b0; rx_active = 1'b0; loopback = 1'b0;
        step(100);

        // Inverted output polarity.
        alt_polarity = 1'b1;
        exp_crs(1, 1'b1, "R11"); exp_coll(1, 1'b1, "R11");
        step(1);
        rx_active = 1'b1; exp_crs(1, 1'b0, "R11");
        step(2);
        coll_run = 1'b1; exp_coll(8, 1'b0, "R11");
        step(10);
        coll_run = 1'b0; rx_active = 1'b0;
        step(20);
        exp_crs(1, 1'b1, "R11"); exp_coll(1, 1'b1, "R11");
        step(3);

        while (sb.size() != 0) step(1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d: actual=hung expected=finished", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule